// File: doc/BRIEF.md
# Interrupt Gate Privilege Checker

This block vets one protected-mode gate entry before an interrupt or exception is dispatched. It takes the vector number, the descriptor table limit, the 8-byte gate entry fetched for that vector, the privilege level the code runs at now (cpl), and the privilege field of the handler's code segment. From these it derives the following in the same cycle:

- the byte offset of the entry;
- the gate kind;
- the handler selector and 32-bit handler offset;
- the privilege level the handler will run at;
- whether the interrupt-enable flag must be dropped;
- whether a stack switch is needed;
- whether a general-protection fault must be raised instead.

The checker is purely combinational. Each output depends only on the inputs present in the same cycle. The interfaces carry no valid/ready handshake: the block never holds data, so it cannot stall. A caller that pipelines around it registers the inputs and outputs itself. Fetching the entry and the code-segment descriptor, and performing a task switch, are left to neighbouring logic.

Top module: `gate_priv_checker`

## Requirements
- R1: `entry_offset` equals `vector` multiplied by eight, zero-extended to `VEC_W+3` bits.
- R2: `gp_fault` is 1 whenever `entry_offset + 7` is greater than `tbl_limit`, which means the entry does not lie wholly inside the table.
- R3: The type field is `gate_desc[43:40]`. The value 0x5 reports a task gate (`gate_kind` = 1), 0xE an interrupt gate (`gate_kind` = 2) and 0xF a trap gate (`gate_kind` = 3). Every other value reports `gate_kind` = 0 and raises `gp_fault`.
- R4: A clear present bit `gate_desc[47]` raises `gp_fault`.
- R5: For interrupt and trap gates, `gp_fault` is raised when `cpl` is numerically greater than the gate privilege field `gate_desc[46:45]`.
- R6: For interrupt and trap gates, `gp_fault` is raised when `cpl` is numerically less than `cs_dpl`. This forbids entering a less privileged handler.
- R7: The requested-privilege bits of the gate's selector (`gate_desc[17:16]`) never change `gp_fault`, `clear_if` or `stack_switch`.
- R8: `clear_if` is 1 only for a non-faulting interrupt gate. A trap gate, a task gate and any faulting entry give 0.
- R9: For interrupt and trap gates, `target_pl` equals `cs_dpl`. `stack_switch` is 1 exactly when there is no fault and `cs_dpl` is numerically less than `cpl`.
- R10: For interrupt and trap gates, `handler_sel` is `gate_desc[31:16]` and `handler_off` is `{gate_desc[63:48], gate_desc[15:0]}`.
- R11: For a task gate, no privilege comparison is made: only the range and present checks can fault. In addition, `clear_if` is 0, `stack_switch` is 0 and `target_pl` equals `cpl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpl | input | 2 | Privilege level of the interrupted code |
| gate_desc | input | 64 | Gate entry fetched for the vector |
| cs_dpl | input | 2 | Privilege field of the handler code segment |
| vector | input | VEC_W (8) | Interrupt vector number |
| tbl_limit | input | LIM_W (16) | Last valid byte offset of the table |
| entry_offset | output | VEC_W+3 (11) | Byte offset of the entry in the table |
| gate_kind | output | 2 | 0 illegal, 1 task, 2 interrupt, 3 trap |
| handler_sel | output | 16 | Handler code-segment selector |
| handler_off | output | 32 | Handler entry offset |
| target_pl | output | 2 | Privilege level the handler runs at |
| clear_if | output | 1 | Interrupt-enable flag must be cleared |
| stack_switch | output | 1 | Handler needs a new stack |
| gp_fault | output | 1 | General-protection fault instead of dispatch |

## Verification
The bench drives the limit so that the entry's last byte lands exactly on it, and then one byte past it. A design that compares the first byte of the entry instead of the last would let a half-outside entry through.

It sets `cpl` equal to each privilege field in turn. A design that swaps the direction of either comparison, or uses a strict test, faults on a legal pair or admits an illegal one.

It feeds task gates whose privilege fields would fail, flips the selector's requested-privilege bits, and sweeps every type code. A design that applies privilege checks to task gates, reads the RPL, or confuses interrupt and trap gates shows the error in `gp_fault` or `clear_if`.

// File: rtl/gate_chk_pkg.sv
package gate_chk_pkg;

  typedef enum logic [1:0] {
    GK_NONE = 2'd0,
    GK_TASK = 2'd1,
    GK_INTR = 2'd2,
    GK_TRAP = 2'd3
  } gate_kind_e;

  localparam logic [3:0] TY_TASK = 4'h5;
  localparam logic [3:0] TY_INTR = 4'hE;
  localparam logic [3:0] TY_TRAP = 4'hF;

  localparam int DESC_W   = 64;
  localparam int SEL_W    = 16;
  localparam int OFF_W    = 32;
  localparam int PL_W     = 2;
  localparam int ENTRY_SH = 3;

endpackage

// File: rtl/gate_desc_decode.sv
module gate_desc_decode
  import gate_chk_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output gate_kind_e        kind,
  output logic [SEL_W-1:0]  sel,
  output logic [OFF_W-1:0]  off,
  output logic [PL_W-1:0]   gate_dpl,
  output logic              present
);

  logic [3:0] ty;
  logic       unused_desc_bits;

  assign ty               = desc[43:40];
  assign gate_dpl         = desc[46:45];
  assign present          = desc[47];
  assign sel              = desc[31:16];
  assign off              = {desc[63:48], desc[15:0]};
  assign unused_desc_bits = ^{desc[44], desc[39:32]};

  always_comb begin
    unique case (ty)
      TY_TASK: kind = GK_TASK;
      TY_INTR: kind = GK_INTR;
      TY_TRAP: kind = GK_TRAP;
      default: kind = GK_NONE;
    endcase
  end

  always_comb begin
    // R3
    decode_kind_chk: assert ((kind == GK_NONE) || (ty == TY_TASK) || (ty[3:1] == 3'b111))
      else $error("decoded kind without legal type code");
  end

endmodule

// File: rtl/gate_span_check.sv
module gate_span_check #(
  parameter int VEC_W = 8,
  parameter int LIM_W = 16
) (
  input  logic [VEC_W-1:0]   vector,
  input  logic [LIM_W-1:0]   limit,
  output logic [VEC_W+2:0]   entry_offset,
  output logic               out_of_range
);

  localparam int ENT_W  = VEC_W + 3;
  localparam int CMP_W  = ((ENT_W > LIM_W) ? ENT_W : LIM_W) + 1;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] lim_ext;

  assign entry_offset = {vector, 3'b000};
  assign last_byte    = CMP_W'(entry_offset) + CMP_W'(7);
  assign lim_ext      = CMP_W'(limit);
  assign out_of_range = last_byte > lim_ext;

  always_comb begin
    // R2
    span_first_byte_chk: assert (out_of_range || (CMP_W'(entry_offset) <= lim_ext))
      else $error("entry in range but first byte beyond limit");
  end

endmodule

// File: rtl/gate_priv_eval.sv
module gate_priv_eval
  import gate_chk_pkg::*;
(
  input  gate_kind_e      kind,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] gate_dpl,
  input  logic [PL_W-1:0] cs_dpl,
  output logic            priv_ok,
  output logic            switch_needed
);

  logic call_like;
  logic gate_reachable;
  logic handler_not_lower;

  assign call_like         = (kind == GK_INTR) || (kind == GK_TRAP);
  assign gate_reachable    = cpl <= gate_dpl;
  assign handler_not_lower = cpl >= cs_dpl;

  always_comb begin
    if (call_like) begin
      priv_ok       = gate_reachable && handler_not_lower;
      switch_needed = cs_dpl < cpl;
    end else begin
      priv_ok       = 1'b1;
      switch_needed = 1'b0;
    end
  end

  always_comb begin
    // R5
    priv_order_chk: assert (!(call_like && priv_ok) || (cs_dpl <= gate_dpl))
      else $error("passing gate with handler below gate privilege");
  end

endmodule

// File: rtl/gate_priv_checker.sv
module gate_priv_checker
  import gate_chk_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LIM_W = 16
) (
  input  logic [1:0]       cpl,
  input  logic [63:0]      gate_desc,
  input  logic [1:0]       cs_dpl,
  input  logic [VEC_W-1:0] vector,
  input  logic [LIM_W-1:0] tbl_limit,
  output logic [VEC_W+2:0] entry_offset,
  output logic [1:0]       gate_kind,
  output logic [15:0]      handler_sel,
  output logic [31:0]      handler_off,
  output logic [1:0]       target_pl,
  output logic             clear_if,
  output logic             stack_switch,
  output logic             gp_fault
);

  gate_kind_e      kind;
  logic [PL_W-1:0] gate_dpl;
  logic            present;
  logic            out_of_range;
  logic            priv_ok;
  logic            switch_needed;
  logic            call_like;

  gate_desc_decode u_decode (
    .desc     (gate_desc),
    .kind     (kind),
    .sel      (handler_sel),
    .off      (handler_off),
    .gate_dpl (gate_dpl),
    .present  (present)
  );

  gate_span_check #(.VEC_W(VEC_W), .LIM_W(LIM_W)) u_span (
    .vector       (vector),
    .limit        (tbl_limit),
    .entry_offset (entry_offset),
    .out_of_range (out_of_range)
  );

  gate_priv_eval u_priv (
    .kind          (kind),
    .cpl           (cpl),
    .gate_dpl      (gate_dpl),
    .cs_dpl        (cs_dpl),
    .priv_ok       (priv_ok),
    .switch_needed (switch_needed)
  );

  assign call_like    = (kind == GK_INTR) || (kind == GK_TRAP);
  assign gate_kind    = kind;
  assign gp_fault     = out_of_range || (kind == GK_NONE) || !present || !priv_ok;
  assign clear_if     = !gp_fault && (kind == GK_INTR);
  assign stack_switch = !gp_fault && switch_needed;
  assign target_pl    = call_like ? cs_dpl : cpl;

  always_comb begin
    // R2
    range_fault_chk: assert (!out_of_range || gp_fault)
      else $error("entry outside table without fault");
    // R4
    absent_fault_chk: assert (present || gp_fault)
      else $error("absent gate without fault");
    // R9
    stack_switch_chk: assert (!stack_switch || (target_pl < cpl))
      else $error("stack switch without privilege rise");
    // R11
    task_quiet_chk: assert ((kind != GK_TASK) || (!stack_switch && !clear_if))
      else $error("task gate requested switch or IF clear");
  end

endmodule

// File: tb/tb_gate_priv_checker.sv
`timescale 1ns/1ps
module tb_gate_priv_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpl = '0;
  logic [63:0] gate_desc = '0;
  logic [1:0]  cs_dpl = '0;
  logic [7:0]  vector = '0;
  logic [15:0] tbl_limit = '0;
  logic [10:0] entry_offset;
  logic [1:0]  gate_kind;
  logic [15:0] handler_sel;
  logic [31:0] handler_off;
  logic [1:0]  target_pl;
  logic        clear_if;
  logic        stack_switch;
  logic        gp_fault;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  gate_priv_checker dut (
    .cpl(cpl), .gate_desc(gate_desc), .cs_dpl(cs_dpl), .vector(vector),
    .tbl_limit(tbl_limit), .entry_offset(entry_offset), .gate_kind(gate_kind),
    .handler_sel(handler_sel), .handler_off(handler_off), .target_pl(target_pl),
    .clear_if(clear_if), .stack_switch(stack_switch), .gp_fault(gp_fault)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int ty, input int p, input int dpl,
                                     input logic [15:0] sel, input logic [31:0] off);
    logic [63:0] d;
    d = '0;
    d[15:0]  = off[15:0];
    d[63:48] = off[31:16];
    d[31:16] = sel;
    d[43:40] = 4'(ty);
    d[46:45] = 2'(dpl);
    d[47]    = p[0];
    return d;
  endfunction

  // Behavioural reference: expected outputs from the requirements.
  task automatic compare(input string tag);
    int ty, kind, gdpl, c, cd, last, lim;
    bit pres, fault, ok;
    ty   = int'(gate_desc[43:40]);
    gdpl = int'(gate_desc[46:45]);
    pres = gate_desc[47];
    c    = int'(cpl);
    cd   = int'(cs_dpl);
    kind = (ty == 5) ? 1 : (ty == 14) ? 2 : (ty == 15) ? 3 : 0;
    last = int'(vector) * 8 + 7;
    lim  = int'(tbl_limit);
    ok   = 1;
    if (kind == 2 || kind == 3) ok = (c <= gdpl) && (c >= cd);
    fault = (last > lim) || (kind == 0) || !pres || !ok;
    chk({"R1 ", tag}, "entry_offset", entry_offset, vector * 8);
    chk({"R3 ", tag}, "gate_kind", gate_kind, kind);
    chk({"R2/R4/R5/R6 ", tag}, "gp_fault", gp_fault, fault);
    chk({"R8 ", tag}, "clear_if", clear_if, (!fault && kind == 2));
    if (kind == 2 || kind == 3) begin
      chk({"R9 ", tag}, "target_pl", target_pl, cd);
      chk({"R9 ", tag}, "stack_switch", stack_switch, (!fault && cd < c));
      chk({"R10 ", tag}, "handler_sel", handler_sel, gate_desc[31:16]);
      chk({"R10 ", tag}, "handler_off", handler_off, {gate_desc[63:48], gate_desc[15:0]});
    end else begin
      chk({"R11 ", tag}, "target_pl", target_pl, c);
      chk({"R11 ", tag}, "stack_switch", stack_switch, 0);
    end
  endtask

  task automatic apply(input int c, input logic [63:0] d, input int cd,
                       input int v, input int lim, input string tag);
    @(posedge clk);
    cpl = 2'(c); gate_desc = d; cs_dpl = 2'(cd);
    vector = 8'(v); tbl_limit = 16'(lim);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic sw_a, f_a, ci_a;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: all-zero entry is illegal type, faults
    chk("R3 reset", "gp_fault", gp_fault, 1);
    chk("R3 reset", "gate_kind", gate_kind, 0);
    compare("reset");

    // R2: limit exactly covers last byte, then one short
    apply(0, mk(14, 1, 3, 16'h0008, 32'h1234_5678), 0, 32, 32*8+7, "R2 edge in");
    chk("R2", "gp_fault at exact limit", gp_fault, 0);
    apply(0, mk(14, 1, 3, 16'h0008, 32'h1234_5678), 0, 32, 32*8+6, "R2 edge out");
    chk("R2", "gp_fault one short", gp_fault, 1);
    apply(0, mk(15, 1, 3, 16'h0010, 32'hCAFE_0001), 0, 255, 16'hFFFF, "R1 top vector");

    // R3: sweep all type codes
    for (int t = 0; t < 16; t++)
      apply(1, mk(t, 1, 3, 16'h0018, 32'h0000_1000), 0, 3, 16'h07FF, "R3 sweep");

    // R4: absent gate
    apply(0, mk(14, 0, 3, 16'h0008, 32'h0), 0, 1, 16'h07FF, "R4 absent");
    chk("R4", "gp_fault absent", gp_fault, 1);

    // R5/R6: every privilege combination for interrupt and trap gates
    for (int k = 14; k < 16; k++)
      for (int c = 0; c < 4; c++)
        for (int g = 0; g < 4; g++)
          for (int cd = 0; cd < 4; cd++)
            apply(c, mk(k, 1, g, 16'h0020, 32'h00AB_CD00), cd, 7, 16'h07FF, "R5 R6 R9 grid");

    // R11: task gate with failing privilege fields still passes
    apply(3, mk(5, 1, 0, 16'h0028, 32'h0), 0, 9, 16'h07FF, "R11 task");
    chk("R11", "task gp_fault", gp_fault, 0);
    chk("R11", "task gate_kind", gate_kind, 1);

    // R7: RPL bits have no effect
    for (int r = 0; r < 4; r++) begin
      apply(2, mk(14, 1, 3, 16'h0030 | 16'(r), 32'h0), 1, 4, 16'h07FF, "R7 rpl");
      if (r == 0) begin
        sw_a = stack_switch; f_a = gp_fault; ci_a = clear_if;
      end else begin
        chk("R7", "gp_fault vs rpl", gp_fault, f_a);
        chk("R7", "stack_switch vs rpl", stack_switch, sw_a);
        chk("R7", "clear_if vs rpl", clear_if, ci_a);
      end
    end

    // R8: interrupt vs trap with identical fields
    apply(0, mk(15, 1, 0, 16'h0008, 32'h0), 0, 2, 16'h07FF, "R8 trap");
    chk("R8", "trap clear_if", clear_if, 0);
    apply(0, mk(14, 1, 0, 16'h0008, 32'h0), 0, 2, 16'h07FF, "R8 intr");
    chk("R8", "intr clear_if", clear_if, 1);

    // mixed pseudo-random patterns
    for (int i = 0; i < 600; i++) begin
      int pick, ty;
      pick = $urandom_range(0, 7);
      ty = (pick < 2) ? 14 : (pick < 4) ? 15 : (pick < 6) ? 5 : $urandom_range(0, 15);
      apply($urandom_range(0, 3),
            mk(ty, ($urandom_range(0, 9) != 0), $urandom_range(0, 3),
               16'($urandom), 32'($urandom)),
            $urandom_range(0, 3), $urandom_range(0, 255),
            ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2047) : 2047, "R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule